// File: doc/BRIEF.md
# Flash command sequence decoder

This block sits between a processor's simple synchronous bus and a modelled flash array. It watches writes that fall in the array window and picks out multi-cycle unlock sequences. A six-write sequence erases one 4 KiB sector to all ones. A four-write sequence programs one byte. Programming can only clear bits, because the new value is ANDed into the stored byte. Software follows the unlock address/data pattern and then polls the array. While an operation is in progress, every array read returns a status byte whose bit 6 inverts from one read to the next. Once two reads in a row match, the operation is over and reads return stored data again.

Two control registers sit outside the array. A mode register selects normal read use (3'b010) or command use (3'b101). A key register opens command entry with one key value and closes it with another. Command entry is possible only while both are set for it and no operation is busy.

The decoder state machine has seven states. S_IDLE goes to S_KEY1 when the first unlock write arrives. S_KEY1 goes to S_KEY2 on the second unlock write. From S_KEY2, the erase setup write leads to S_ERA_ARM and the program setup write leads to S_PRG_ARM. S_ERA_ARM goes to S_ERA_KEY1 and then S_ERA_KEY2 on the repeated unlock pair. S_ERA_KEY2 returns to S_IDLE and launches an erase when the confirm write arrives. S_PRG_ARM returns to S_IDLE and launches a program on the next array write. Any array write that does not match the expected step takes the machine back to S_IDLE. So does a closed gate.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, op_busy is 0, every array byte reads 0xFF, the mode register reads 0x40 and the key register reads 0x00.
- R2: The mode register at 0x0FD0 holds a 3-bit field in write-data bits [7:5] and reads back as {field, 5'b0}. The key register at 0x0FD1 is set open by 0x2A and closed by 0xD5, ignores other values, and reads back as {7'b0, open}. Commands are accepted only when the key register is open and the field equals 3'b101.
- R3: The writes 0xF555←0xAA, 0xFAAA←0x55, 0xF555←0xA0, then T←D, replace the byte at T with (old & D).
- R4: The writes 0xF555←0xAA, 0xFAAA←0x55, 0xF555←0x80, 0xF555←0xAA, 0xFAAA←0x55, then any address in a sector ←0x30, set every byte of that sector (addr[15:12]) to 0xFF and leave other sectors unchanged.
- R5: An array write that does not match the expected address/data for the current step returns the decoder to idle. It changes no byte. The sequence must then start again from its first write. A plain array write outside a sequence changes nothing.
- R6: op_busy rises in the cycle after the final command write and stays high for exactly BUSY_CYCLES cycles. Command writes made while it is high have no effect.
- R7: While busy, an array read returns a status byte in which only bit 6 may be set. Bit 6 is 0 on the first read after launch and inverts on every later array read.
- R8: After busy ends, array reads return stored data, and two consecutive reads of the same byte are equal.
- R9: Command writes made while the key register is closed or the mode field is not 3'b101 change no byte. Closing the key mid-sequence abandons the sequence.
- R10: The array occupies sectors 0x8 to 0xF (0x8000 to 0xFFFF). The model keeps addr[5:0] within each sector, so addresses that differ only in bits [11:6] alias. Reads of other non-register addresses return 0x00. bus_rdata is registered and updates at the clock edge where bus_rd is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Byte address of the current access |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data or status byte |
| op_busy | output | 1 | High while an erase or program is in progress |

## Verification
The decoder is driven with complete program and erase sequences and with a sequence broken at the second step. It is also given an erase sequence whose confirm data is wrong, a program sequence cut off by closing the key, and lone data writes. A correct decoder launches only on the complete patterns. A decoder that restarts on any unlock-looking write, or that skips address checks, changes bytes that must stay put. Sequences are also sent while the gate is closed and while an erase is busy, so that the gate and the busy block can be told apart. The reads that follow a launch check the alternating status byte, and the reads after completion check the data. Repeated programs of one byte show ANDing rather than overwriting, and a read through an alias address confirms the address mapping.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    // unlock pattern and command codes
    localparam logic [ADDR_W-1:0] UNL_ADDR_A      = 16'hF555;
    localparam logic [ADDR_W-1:0] UNL_ADDR_B      = 16'hFAAA;
    localparam logic [DATA_W-1:0] UNL_DATA_A      = 8'hAA;
    localparam logic [DATA_W-1:0] UNL_DATA_B      = 8'h55;
    localparam logic [DATA_W-1:0] CMD_ERASE_SETUP = 8'h80;
    localparam logic [DATA_W-1:0] CMD_PROG_SETUP  = 8'hA0;
    localparam logic [DATA_W-1:0] CMD_ERASE_CONF  = 8'h30;

    // control register keys and mode codes
    localparam logic [DATA_W-1:0] KEY_CLOSE  = 8'hD5;
    localparam logic [DATA_W-1:0] KEY_OPEN   = 8'h2A;
    localparam logic [2:0]        MODE_NORMAL = 3'b010;
    localparam logic [2:0]        MODE_CMD    = 3'b101;

    localparam int TGL_BIT = 6;

    typedef enum logic [2:0] {
        S_IDLE,
        S_KEY1,
        S_KEY2,
        S_ERA_ARM,
        S_ERA_KEY1,
        S_ERA_KEY2,
        S_PRG_ARM
    } seq_state_e;

endpackage

// File: rtl/fcs_ctrl_regs.sv
module fcs_ctrl_regs
    import fcs_pkg::*;
#(
    parameter logic [ADDR_W-1:0] MODE_REG_ADDR = 16'h0FD0,
    parameter logic [ADDR_W-1:0] KEY_REG_ADDR  = 16'h0FD1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [2:0]        mode,
    output logic              key_open,
    output logic              cmd_open
);

    logic [2:0] mode_q;
    logic       open_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_NORMAL;
            open_q <= 1'b0;
        end else if (wr) begin
            if (addr == MODE_REG_ADDR) begin
                mode_q <= wdata[DATA_W-1 -: 3];
            end
            if (addr == KEY_REG_ADDR) begin
                if (wdata == KEY_CLOSE) begin
                    open_q <= 1'b0;
                end else if (wdata == KEY_OPEN) begin
                    open_q <= 1'b1;
                end
            end
        end
    end

    assign mode     = mode_q;
    assign key_open = open_q;
    assign cmd_open = open_q && (mode_q == MODE_CMD);

    AST_CLOSE_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == KEY_REG_ADDR && wdata == KEY_CLOSE) |=> !cmd_open); // R9

    AST_OPEN_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == MODE_REG_ADDR && wdata[DATA_W-1 -: 3] != MODE_CMD) |=> !cmd_open); // R2

endmodule

// File: rtl/fcs_seq_fsm.sv
module fcs_seq_fsm
    import fcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arr_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cmd_ok,
    output logic              erase_go,
    output logic              prog_go
);

    seq_state_e state_q;
    seq_state_e state_d;

    logic hit_a;
    logic hit_b;
    logic at_a;

    assign at_a  = (addr == UNL_ADDR_A);
    assign hit_a = at_a && (wdata == UNL_DATA_A);
    assign hit_b = (addr == UNL_ADDR_B) && (wdata == UNL_DATA_B);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!cmd_ok) begin
            state_d = S_IDLE;
        end else if (arr_wr) begin
            unique case (state_q)
                S_IDLE:     state_d = hit_a ? S_KEY1 : S_IDLE;
                S_KEY1:     state_d = hit_b ? S_KEY2 : S_IDLE;
                S_KEY2: begin
                    if (at_a && wdata == CMD_ERASE_SETUP) begin
                        state_d = S_ERA_ARM;
                    end else if (at_a && wdata == CMD_PROG_SETUP) begin
                        state_d = S_PRG_ARM;
                    end else begin
                        state_d = S_IDLE;
                    end
                end
                S_ERA_ARM:  state_d = hit_a ? S_ERA_KEY1 : S_IDLE;
                S_ERA_KEY1: state_d = hit_b ? S_ERA_KEY2 : S_IDLE;
                S_ERA_KEY2: state_d = S_IDLE;
                S_PRG_ARM:  state_d = S_IDLE;
                default:    state_d = S_IDLE;
            endcase
        end
    end

    // launch outputs
    always_comb begin
        erase_go = 1'b0;
        prog_go  = 1'b0;
        if (cmd_ok && arr_wr) begin
            unique case (state_q)
                S_ERA_KEY2: erase_go = (wdata == CMD_ERASE_CONF);
                S_PRG_ARM:  prog_go  = 1'b1;
                default: begin
                    erase_go = 1'b0;
                    prog_go  = 1'b0;
                end
            endcase
        end
    end

    AST_ONE_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        !(erase_go && prog_go)); // R3

    AST_GATE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ok |=> (state_q == S_IDLE)); // R9

    AST_PROG_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |=> (state_q == S_IDLE)); // R3

    AST_ERASE_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |=> (state_q == S_IDLE)); // R4

endmodule

// File: rtl/fcs_busy_ctr.sv
module fcs_busy_ctr #(
    parameter int BUSY_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic arr_rd,
    output logic busy,
    output logic tgl
);

    localparam int CW = $clog2(BUSY_CYCLES + 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic          tgl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (start) begin
            cnt_q  <= CW'(BUSY_CYCLES - 1);
            busy_q <= 1'b1;
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgl_q <= 1'b0;
        end else if (start) begin
            tgl_q <= 1'b0;
        end else if (busy_q && arr_rd) begin
            tgl_q <= ~tgl_q;
        end
    end

    assign busy = busy_q;
    assign tgl  = tgl_q;

    AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy); // R6

    AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start); // R6

    AST_TGL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && arr_rd && !start) |=> (tgl != $past(tgl))); // R7

    AST_TGL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!arr_rd && !start) |=> $stable(tgl)); // R7

endmodule

// File: rtl/fcs_array.sv
module fcs_array
    import fcs_pkg::*;
#(
    parameter int NUM_SECT = 8,
    parameter int MODEL_AW = 6,
    localparam int SW = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SW-1:0]       sect_idx,
    input  logic [MODEL_AW-1:0] off_idx,
    input  logic                erase_go,
    input  logic                prog_go,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rd_byte
);

    localparam int MODEL_BYTES = 1 << MODEL_AW;

    logic [DATA_W-1:0] rd_vec [NUM_SECT];

    for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
        logic [DATA_W-1:0] cell_q [MODEL_BYTES];
        logic [DATA_W-1:0] cur_rd;
        logic              hit;

        assign hit    = (sect_idx == SW'(s));
        assign cur_rd = cell_q[off_idx];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int i = 0; i < MODEL_BYTES; i++) begin
                    cell_q[i] <= '1;
                end
            end else if (erase_go && hit) begin
                for (int i = 0; i < MODEL_BYTES; i++) begin
                    cell_q[i] <= '1;
                end
            end else if (prog_go && hit) begin
                cell_q[off_idx] <= cur_rd & wdata;
            end
        end

        assign rd_vec[s] = cur_rd;

        AST_ERASE_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
            (erase_go && hit) |=> (cell_q[0] == '1 && cell_q[MODEL_BYTES-1] == '1)); // R4

        AST_PROG_AND: assert property (@(posedge clk) disable iff (!rst_n)
            (prog_go && hit && !erase_go) |=>
                (cell_q[$past(off_idx)] == ($past(cur_rd) & $past(wdata)))); // R3
    end

    assign rd_byte = rd_vec[sect_idx];

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int                SECT_AW       = 12,
    parameter int                FIRST_SECT    = 8,
    parameter int                NUM_SECT      = 8,
    parameter int                MODEL_AW      = 6,
    parameter int                BUSY_CYCLES   = 20,
    parameter logic [15:0]       MODE_REG_ADDR = 16'h0FD0,
    parameter logic [15:0]       KEY_REG_ADDR  = 16'h0FD1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] bus_addr,
    input  logic [7:0]  bus_wdata,
    input  logic        bus_wr,
    input  logic        bus_rd,
    output logic [7:0]  bus_rdata,
    output logic        op_busy
);

    localparam int HW = ADDR_W - SECT_AW;
    localparam int SW = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1;

    logic [HW:0]         rel_sect;
    logic                in_array;
    logic [SW-1:0]       sect_idx;
    logic [MODEL_AW-1:0] off_idx;
    logic                arr_wr;
    logic                arr_rd;

    logic [2:0]          mode;
    logic                key_open;
    logic                cmd_open;
    logic                cmd_ok;
    logic                erase_go;
    logic                prog_go;
    logic                busy;
    logic                tgl;
    logic [DATA_W-1:0]   arr_byte;
    logic [DATA_W-1:0]   rdata_q;

    // address decode
    assign rel_sect = {1'b0, bus_addr[ADDR_W-1:SECT_AW]} - (HW+1)'(FIRST_SECT);
    assign in_array = (rel_sect < (HW+1)'(NUM_SECT));
    assign sect_idx = rel_sect[SW-1:0];
    assign off_idx  = bus_addr[MODEL_AW-1:0];
    assign arr_wr   = bus_wr && in_array;
    assign arr_rd   = bus_rd && in_array;
    assign cmd_ok   = cmd_open && !busy;

    fcs_ctrl_regs #(
        .MODE_REG_ADDR (MODE_REG_ADDR),
        .KEY_REG_ADDR  (KEY_REG_ADDR)
    ) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .mode     (mode),
        .key_open (key_open),
        .cmd_open (cmd_open)
    );

    fcs_seq_fsm seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .arr_wr   (arr_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .cmd_ok   (cmd_ok),
        .erase_go (erase_go),
        .prog_go  (prog_go)
    );

    fcs_busy_ctr #(
        .BUSY_CYCLES (BUSY_CYCLES)
    ) busy_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (erase_go || prog_go),
        .arr_rd (arr_rd),
        .busy   (busy),
        .tgl    (tgl)
    );

    fcs_array #(
        .NUM_SECT (NUM_SECT),
        .MODEL_AW (MODEL_AW)
    ) array_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sect_idx (sect_idx),
        .off_idx  (off_idx),
        .erase_go (erase_go),
        .prog_go  (prog_go),
        .wdata    (bus_wdata),
        .rd_byte  (arr_byte)
    );

    // registered read path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            if (in_array) begin
                rdata_q <= busy ? (DATA_W'(tgl) << TGL_BIT) : arr_byte;
            end else if (bus_addr == MODE_REG_ADDR) begin
                rdata_q <= {mode, 5'b0};
            end else if (bus_addr == KEY_REG_ADDR) begin
                rdata_q <= {7'b0, key_open};
            end else begin
                rdata_q <= '0;
            end
        end
    end

    assign bus_rdata = rdata_q;
    assign op_busy   = busy;

    AST_STATUS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_rd && busy) |=> ((bus_rdata & ~(8'h1 << TGL_BIT)) == '0)); // R7

    AST_LOCKED_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_open) |=> !$rose(op_busy)); // R9

endmodule

// File: tb/flash_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb_top;

    localparam int BUSY = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        op_busy;

    int n_chk  = 0;
    int n_fail = 0;

    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       rd_seen = 1'b0;

    always #4 clk = ~clk;

    flash_cmd_seq #(.BUSY_CYCLES(BUSY)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .op_busy   (op_busy)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read data one cycle after each read strobe
    always @(posedge clk) rd_seen <= bus_rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                chk("scoreboard underflow", 8'h01, 8'h00);
            end else begin
                chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic prog_seq(input logic [15:0] a, input logic [7:0] d);
        wr(16'hF555, 8'hAA);
        wr(16'hFAAA, 8'h55);
        wr(16'hF555, 8'hA0);
        wr(a, d);
    endtask

    task automatic erase_seq(input logic [15:0] a);
        wr(16'hF555, 8'hAA);
        wr(16'hFAAA, 8'h55);
        wr(16'hF555, 8'h80);
        wr(16'hF555, 8'hAA);
        wr(16'hFAAA, 8'h55);
        wr(a, 8'h30);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (op_busy) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : stim
        int cnt;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 busy after reset", {7'b0, op_busy}, 8'h00);
        rd(16'h8000, 8'hFF, "R1 erased array");
        rd(16'h0FD0, 8'h40, "R1 mode reset");
        rd(16'h0FD1, 8'h00, "R1 key reset");

        // R9 closed key: program ignored
        prog_seq(16'h9000, 8'h00);
        @(negedge clk);
        chk("R9 no busy when closed", {7'b0, op_busy}, 8'h00);
        rd(16'h9000, 8'hFF, "R9 closed key no change");

        // R2/R9 key open but normal mode
        wr(16'h0FD1, 8'h2A);
        rd(16'h0FD1, 8'h01, "R2 key reads open");
        prog_seq(16'h9000, 8'h00);
        rd(16'h9000, 8'hFF, "R9 wrong mode no change");
        wr(16'h0FD0, 8'hA0);
        rd(16'h0FD0, 8'hA0, "R2 mode readback");
        wr(16'h0FD1, 8'h77);
        rd(16'h0FD1, 8'h01, "R2 other key ignored");

        // R3 program with status polling (R7), then data (R8)
        prog_seq(16'h9003, 8'h3C);
        rd(16'h9003, 8'h00, "R7 first status read");
        rd(16'h9003, 8'h40, "R7 second status read");
        rd(16'h9003, 8'h00, "R7 third status read");
        wait_idle();
        rd(16'h9003, 8'h3C, "R3 program stored");
        rd(16'h9003, 8'h3C, "R8 repeated read equal");

        // R3 AND behaviour, R6 busy length
        prog_seq(16'h9003, 8'hF0);
        cnt = 0;
        @(negedge clk);
        while (op_busy) begin cnt++; @(negedge clk); end
        chk("R6 busy length", 8'(cnt), 8'(BUSY));
        rd(16'h9003, 8'h30, "R3 program ANDs");

        // R10 aliasing and unmapped space
        rd(16'h9043, 8'h30, "R10 alias in sector");
        rd(16'h1234, 8'h00, "R10 unmapped reads zero");

        // R4 erase, R6 writes during busy ignored
        prog_seq(16'hA010, 8'h55);
        wait_idle();
        erase_seq(16'h9ABC);
        rd(16'h9003, 8'h00, "R7 erase status 1");
        rd(16'h9003, 8'h40, "R7 erase status 2");
        prog_seq(16'hA010, 8'h00);
        rd(16'hA010, 8'h00, "R7 status after writes");
        wait_idle();
        rd(16'h9003, 8'hFF, "R4 sector erased");
        rd(16'h9043, 8'hFF, "R4 alias erased");
        rd(16'hA010, 8'h55, "R6 busy write ignored, R4 other sector kept");

        // R5 broken unlock, then leftover steps
        wr(16'hF555, 8'hAA);
        wr(16'hFAAA, 8'h56);
        wr(16'hF555, 8'hA0);
        wr(16'hA010, 8'h00);
        @(negedge clk);
        chk("R5 no launch after mismatch", {7'b0, op_busy}, 8'h00);
        rd(16'hA010, 8'h55, "R5 mismatch no change");

        // R5 wrong erase confirm
        wr(16'hF555, 8'hAA);
        wr(16'hFAAA, 8'h55);
        wr(16'hF555, 8'h80);
        wr(16'hF555, 8'hAA);
        wr(16'hFAAA, 8'h55);
        wr(16'hA000, 8'h31);
        rd(16'hA010, 8'h55, "R5 bad confirm no erase");

        // R5 plain write ignored
        wr(16'hA010, 8'h00);
        rd(16'hA010, 8'h55, "R5 plain write ignored");

        // R9 close key mid-sequence
        wr(16'hF555, 8'hAA);
        wr(16'hFAAA, 8'h55);
        wr(16'hF555, 8'hA0);
        wr(16'h0FD1, 8'hD5);
        wr(16'hA010, 8'h00);
        rd(16'hA010, 8'h55, "R9 abort by close");
        rd(16'h0FD1, 8'h00, "R2 key reads closed");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) chk("scoreboard leftover", 8'(exp_q.size()), 8'h00);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule